// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block encrypts 128-bit data blocks under 128-bit keys with the AES cipher. The ten rounds are fully unrolled, and each round has its own register stage. A new plaintext and a new key may be presented on every clock cycle. The round keys are derived stage by stage in a pipeline that runs beside the data, so consecutive blocks may use unrelated keys. No reload or setup phase is needed between blocks.

Bytes are numbered from the top of the vector: byte 0 is bits 127:120 and byte 15 is bits 7:0. Bytes fill the 4x4 state matrix column by column, so byte 4c+r sits in row r of column c. The input register also applies the whitening step, which XORs the raw key into the state. Each of the ten round stages then performs byte substitution, row rotation (row r moves left by r positions), column mixing and the round-key XOR. Stage ten skips the column mixing. A valid flag moves through the stages with its block, and a stage loads new data only when that flag is set.

Top module: `aes128_pipe`

## Requirements
- R1: When in_valid is high at a rising edge, out_valid is high after the 11th rising edge counted from and including that edge, and not earlier.
- R2: Blocks presented on back-to-back cycles leave on back-to-back cycles, in the order they entered, with none lost.
- R3: Key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: Each block is encrypted under the key presented with it, even when the key changes on every cycle.
- R5: While rst_n is low, and for the first 11 cycles after it is released, out_valid stays low.
- R6: A cycle with in_valid low produces a cycle with out_valid low 11 cycles later.
- R7: out_block equals the AES-128 encryption of the matching input, with bytes ordered as stated above, for plaintexts that cover all 256 byte values.
- R8: out_block keeps its value on every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid flags |
| in_valid | input | 1 | A block and key are presented this cycle |
| in_block | input | 128 | Plaintext, byte 0 in bits 127:120 |
| in_key | input | 128 | Cipher key for this block, same byte order |
| out_valid | output | 1 | out_block holds a new ciphertext |
| out_block | output | 128 | Ciphertext |

## Verification
The embedded assertions check on every cycle that the valid flag emerges exactly 11 cycles after it enters, that nothing emerges during warm-up or after an idle input cycle, and that the ciphertext register does not move while out_valid is low. Whether the ciphertext is correct can only be shown by the bench's scenarios. These include the standard vector, a key that changes on every cycle, a 256-block sweep that drives every byte value through the substitution stage, and a gapped stream. Each result is compared against an AES model written separately in the bench.

// File: rtl/aes128_pipe.sv
module aes128_pipe (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] in_block,
  input  logic [127:0] in_key,
  output logic         out_valid,
  output logic [127:0] out_block
);
  localparam int NR = 10;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] sq, inv;
    sq  = a;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int j = 1; j < n; j++) r = xt(r);
    return r;
  endfunction

  function automatic logic [127:0] key_next(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] t, n0, n1, n2, n3;
    t  = {sbox(k[23:16]) ^ rc, sbox(k[15:8]), sbox(k[7:0]), sbox(k[31:24])};
    n0 = k[127:96] ^ t;
    n1 = k[95:64] ^ n0;
    n2 = k[63:32] ^ n1;
    n3 = k[31:0] ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  function automatic logic [127:0] round_f(input logic [127:0] s, input logic [127:0] k,
                                           input logic last);
    logic [7:0] b [16];
    logic [7:0] m [16];
    logic [7:0] a0, a1, a2, a3;
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        b[4*c+r] = sbox(s[127-8*(4*((c+r)%4)+r) -: 8]);
    for (int c = 0; c < 4; c++) begin
      a0 = b[4*c]; a1 = b[4*c+1]; a2 = b[4*c+2]; a3 = b[4*c+3];
      if (last) begin
        m[4*c] = a0; m[4*c+1] = a1; m[4*c+2] = a2; m[4*c+3] = a3;
      end else begin
        m[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
        m[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
        m[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
        m[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
      end
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = m[i] ^ k[127-8*i -: 8];
    return o;
  endfunction

  for (genvar i = 0; i < NR; i++) begin : g_key
    logic [127:0] k;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) if (in_valid) k <= in_key;
    end else begin : g_next
      always_ff @(posedge clk)
        if (g_st[i-1].v) k <= key_next(g_key[i-1].k, rcon(i));
    end
  end

  for (genvar i = 0; i <= NR; i++) begin : g_st
    logic         v;
    logic [127:0] d;
    if (i == 0) begin : g_in
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) v <= 1'b0;
        else        v <= in_valid;
      always_ff @(posedge clk) if (in_valid) d <= in_block ^ in_key;
    end else begin : g_rnd
      logic [127:0] rk;
      assign rk = key_next(g_key[i-1].k, rcon(i));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) v <= 1'b0;
        else        v <= g_st[i-1].v;
      always_ff @(posedge clk)
        if (g_st[i-1].v) d <= round_f(g_st[i-1].d, rk, i == NR);
    end
  end

  assign out_valid = g_st[NR].v;
  assign out_block = g_st[NR].d;

  logic [3:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            age <= '0;
    else if (age != 4'd11) age <= age + 4'd1;

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 4'd11 && $past(in_valid, 11)) |-> out_valid);

  // R5
  warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age < 4'd11) |-> !out_valid);

  // R6
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 4'd11 && !$past(in_valid, 11)) |-> !out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 4'd0 && !out_valid) |-> $stable(out_block));
endmodule

// File: tb/aes128_pipe_test.sv
module aes128_pipe_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_block = '0;
  logic [127:0] in_key = '0;
  logic         out_valid;
  logic [127:0] out_block;

  int checks = 0;
  int failures = 0;
  logic [7:0] sbt [256];
  logic [127:0] exp_q [$];
  string        tag_q [$];
  logic [10:0]  hist = '0;
  logic [127:0] prev_blk = '0;
  logic         have_prev = 1'b0;
  logic [31:0]  seed = 32'h1234_5678;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  aes128_pipe uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
                   .in_key(in_key), .out_valid(out_valid), .out_block(out_block));

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] m2(input logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [31:0] rnd32();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [127:0] rnd128();
    return {rnd32(), rnd32(), rnd32(), rnd32()};
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] w [176];
    logic [7:0] rc, a0, a1, a2, a3, x;
    logic [127:0] o;
    for (int i = 0; i < 16; i++) begin
      w[i] = key[127-8*i -: 8];
      s[i] = pt[127-8*i -: 8] ^ w[i];
    end
    rc = 8'h01;
    for (int i = 16; i < 176; i += 4) begin
      a0 = w[i-4]; a1 = w[i-3]; a2 = w[i-2]; a3 = w[i-1];
      if (i % 16 == 0) begin
        x = a0;
        a0 = sbt[a1] ^ rc; a1 = sbt[a2]; a2 = sbt[a3]; a3 = sbt[x];
        rc = m2(rc);
      end
      w[i] = w[i-16] ^ a0; w[i+1] = w[i-15] ^ a1;
      w[i+2] = w[i-14] ^ a2; w[i+3] = w[i-13] ^ a3;
    end
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) t[i] = sbt[s[(i + 4*(i%4)) % 16]];
      for (int c = 0; c < 4; c++) begin
        a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
        if (r < 10) begin
          x = a0 ^ a1 ^ a2 ^ a3;
          t[4*c]   = a0 ^ x ^ m2(a0 ^ a1);
          t[4*c+1] = a1 ^ x ^ m2(a1 ^ a2);
          t[4*c+2] = a2 ^ x ^ m2(a2 ^ a3);
          t[4*c+3] = a3 ^ x ^ m2(a3 ^ a0);
        end
      end
      for (int i = 0; i < 16; i++) s[i] = t[i] ^ w[16*r+i];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  task automatic send(input bit v, input logic [127:0] pt, input logic [127:0] key,
                      input string tag);
    @(negedge clk);
    in_valid = v;
    in_block = pt;
    in_key   = key;
    if (v) begin
      exp_q.push_back(ref_enc(pt, key));
      tag_q.push_back(tag);
    end
  endtask

  always @(posedge clk)
    if (!rst_n) hist <= '0;
    else        hist <= {hist[9:0], in_valid};

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == hist[10], hist[10] ? "R1 valid timing" : "R6 idle slot",
          {127'b0, out_valid}, {127'b0, hist[10]});
      if (out_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected output", out_block, '0);
        else begin
          logic [127:0] e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          chk(out_block == e, tg, out_block, e);
        end
      end else if (have_prev) begin
        chk(out_block == prev_blk, "R8 hold", out_block, prev_blk);
      end
      prev_blk  = out_block;
      have_prev = 1'b1;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", '0, '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] p, q, x;
    int n;
    p = 8'h01; q = 8'h01;
    for (int i = 0; i < 255; i++) begin
      p = p ^ m2(p);
      q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sbt[p] = x ^ 8'h63;
    end
    sbt[0] = 8'h63;

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5 in reset", {127'b0, out_valid}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R5 after reset", {127'b0, out_valid}, '0);

    send(1'b1, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
         "R3 vector");
    send(1'b0, '0, '0, "");
    n = 1;
    while (!out_valid && n < 30) begin
      @(negedge clk);
      n++;
    end
    chk(n == 11, "R1 latency", n, 11);
    chk(out_block == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 ciphertext", out_block,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    begin
      logic [127:0] pt;
      pt = rnd128();
      for (int i = 0; i < 20; i++) send(1'b1, pt, rnd128(), "R4 per-block key");
    end

    for (int i = 0; i < 256; i++) begin
      logic [127:0] pt;
      for (int j = 0; j < 16; j++) pt[127-8*j -: 8] = 8'(i + 17*j);
      send(1'b1, pt, rnd128(), "R2/R7 sweep");
    end

    for (int i = 0; i < 60; i++)
      send((i % 3) != 1 && (i % 7) != 0, rnd128(), rnd128(), "R6/R7 gapped");

    for (int i = 0; i < 20; i++) send(1'b0, '0, '0, "");
    chk(exp_q.size() == 0, "R2 all delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule